// File: doc/BRIEF.md
# Serial Daisy-Chain Configuration Slave

This block sits at the serial configuration input of one device in a chain. All devices in the chain share a single configuration clock, and the serial output of each device drives the serial input of the next. The block samples the incoming stream on the rising clock edge. It looks for a fixed 8-bit sync pattern and then reads a 24-bit length field, most significant bit first. It keeps this length for the rest of the configuration.

After the header, the slave absorbs a fixed number of bits that belong to its own device. This number is set by the `OWN_BITS` parameter. After that it enters pass-through and raises its loaded flag. Each later bit is retimed onto the serial output at the next falling clock edge, so the next device can sample it on the following rising edge. Before pass-through begins, the serial output rests high. A synchronous reset sends the slave back to searching for the sync pattern.

Top module: `dchain_slave`

## Requirements
- R1: The slave searches the stream for the sync pattern 0xB5, sent most significant bit first, at any bit alignment and after any earlier bits. Until the pattern is seen, length_count stays 0, loaded stays 0 and dout stays 1.
- R2: The 24 bits that follow the sync pattern form length_count, with the first bit as bit 23. length_count reads 0 until the rising edge that samples the 24th length bit, and shows the full value after that edge.
- R3: After the header, exactly OWN_BITS further bits are withheld. dout stays 1 while they arrive and for the falling edge that follows the last of them.
- R4: loaded rises on the rising edge that samples the last withheld bit. It stays high until reset.
- R5: In pass-through, each bit sampled on a rising edge is driven on dout at the next falling edge and held until the falling edge after that.
- R6: Whenever the slave is not in pass-through, dout is 1.
- R7: Once the header is captured, later bits cannot change length_count or restart header capture, even if they contain the sync pattern.
- R8: A rising edge with rst high clears length_count and loaded, clears the bit counters and returns the slave to the sync search. dout is 1 from the next falling edge on.
- R9: With OWN_BITS = 1, loaded rises on the first bit after the header, and forwarding starts with the second bit after the header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cclk | input | 1 | Shared configuration clock; data sampled on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial configuration data in |
| dout | output | 1 | Retimed serial data to the next device, changes on falling edge |
| length_count | output | LEN_W | Length field captured from the header |
| loaded | output | 1 | High once this device's own bits are absorbed |

## Verification
The bench builds two copies of the slave that receive the same stream. One uses OWN_BITS = 16, so a full sync pattern can be hidden inside its own share and a long forwarded tail can be compared bit by bit. The other uses OWN_BITS = 1, the smallest share, where loaded and the first forwarded bit sit right against the end of the header. Between them, the runs reach a stream that starts directly after unrelated data, a stream that starts after idle ones, and a reset issued in the middle of pass-through.

// File: rtl/dchain_pkg.sv
`timescale 1ns/1ps
package dchain_pkg;
  typedef enum logic [1:0] {
    HS_HUNT = 2'd0,
    HS_LEN  = 2'd1,
    HS_DONE = 2'd2
  } hdr_state_e;
endpackage

// File: rtl/dchain_header_rx.sv
`timescale 1ns/1ps
module dchain_header_rx
  import dchain_pkg::*;
#(
  parameter int                PRE_W    = 8,
  parameter logic [PRE_W-1:0]  PREAMBLE = 8'hB5,
  parameter int                LEN_W    = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  output logic             hdr_done,
  output logic [LEN_W-1:0] len_count
);
  localparam int LCW = (LEN_W > 1) ? $clog2(LEN_W) : 1;

  hdr_state_e       st;
  logic [PRE_W-2:0] win;
  logic [LEN_W-2:0] len_sh;
  logic [LEN_W-1:0] len_q;
  logic [LCW-1:0]   lcnt;
  logic [PRE_W-1:0] win_nx;

  // Sliding window over the newest PRE_W bits, newest bit at the LSB.
  assign win_nx = {win, din};

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= HS_HUNT;
      win    <= '1;
      len_sh <= '0;
      len_q  <= '0;
      lcnt   <= '0;
    end else begin
      case (st)
        HS_HUNT: begin
          win <= win_nx[PRE_W-2:0];
          if (win_nx == PREAMBLE) begin
            st   <= HS_LEN;
            lcnt <= '0;
          end
        end
        HS_LEN: begin
          len_sh <= {len_sh[LEN_W-3:0], din};
          lcnt   <= lcnt + LCW'(1);
          if (lcnt == LCW'(LEN_W - 1)) begin
            len_q <= {len_sh, din};
            st    <= HS_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign hdr_done  = (st == HS_DONE);
  assign len_count = len_q;

  // R7
  len_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_done |=> $stable(len_q));

  // R7
  hdr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_done |=> hdr_done);
endmodule

// File: rtl/dchain_own_counter.sv
`timescale 1ns/1ps
module dchain_own_counter #(
  parameter int OWN_BITS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic hdr_done,
  output logic loaded
);
  localparam int CW = (OWN_BITS > 1) ? $clog2(OWN_BITS) : 1;

  logic [CW-1:0] cnt;
  logic          loaded_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      loaded_q <= 1'b0;
    end else if (hdr_done && !loaded_q) begin
      if (cnt == CW'(OWN_BITS - 1)) loaded_q <= 1'b1;
      else                          cnt      <= cnt + CW'(1);
    end
  end

  assign loaded = loaded_q;

  // R4
  loaded_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    loaded_q |=> loaded_q);

  // R4
  loaded_needs_hdr_chk: assert property (@(posedge clk) disable iff (rst)
    loaded_q |-> hdr_done);
endmodule

// File: rtl/dchain_retimer.sv
`timescale 1ns/1ps
module dchain_retimer (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic pass,
  output logic dout
);
  logic rx_bit;
  logic fwd_vld;
  logic dout_q;

  // Rising-edge capture of the incoming bit and whether it is surplus.
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_bit  <= 1'b1;
      fwd_vld <= 1'b0;
    end else begin
      rx_bit  <= din;
      fwd_vld <= pass;
    end
  end

  // Falling-edge relaunch toward the next device.
  always_ff @(negedge clk) begin
    if (rst)          dout_q <= 1'b1;
    else if (fwd_vld) dout_q <= rx_bit;
    else              dout_q <= 1'b1;
  end

  assign dout = dout_q;

  // R5
  fwd_match_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_vld |-> (dout_q == rx_bit));

  // R6
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !fwd_vld |-> dout_q);
endmodule

// File: rtl/dchain_slave.sv
`timescale 1ns/1ps
module dchain_slave #(
  parameter int               PRE_W    = 8,
  parameter logic [PRE_W-1:0] PREAMBLE = 8'hB5,
  parameter int               LEN_W    = 24,
  parameter int               OWN_BITS = 64
) (
  input  logic             cclk,
  input  logic             rst,
  input  logic             din,
  output logic             dout,
  output logic [LEN_W-1:0] length_count,
  output logic             loaded
);
  logic hdr_done;
  logic own_done;

  dchain_header_rx #(
    .PRE_W   (PRE_W),
    .PREAMBLE(PREAMBLE),
    .LEN_W   (LEN_W)
  ) u_hdr (
    .clk      (cclk),
    .rst      (rst),
    .din      (din),
    .hdr_done (hdr_done),
    .len_count(length_count)
  );

  dchain_own_counter #(
    .OWN_BITS(OWN_BITS)
  ) u_own (
    .clk     (cclk),
    .rst     (rst),
    .hdr_done(hdr_done),
    .loaded  (own_done)
  );

  dchain_retimer u_rt (
    .clk (cclk),
    .rst (rst),
    .din (din),
    .pass(own_done),
    .dout(dout)
  );

  assign loaded = own_done;

  // R3
  dout_idle_chk: assert property (@(posedge cclk) disable iff (rst)
    !own_done |-> dout);
endmodule

// File: tb/tb_dchain_slave.sv
`timescale 1ns/1ps
module tb_dchain_slave;
  localparam int CLK_P = 10;
  localparam int LEN_W = 24;
  localparam int OWN_A = 16;
  localparam int OWN_B = 1;
  localparam int MAXB  = 256;

  logic cclk = 1'b0;
  logic rst  = 1'b1;
  logic din  = 1'b1;
  logic dout_a, dout_b, loaded_a, loaded_b;
  logic [LEN_W-1:0] len_a, len_b;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  logic stream [MAXB];
  int   slen;
  logic [15:0] lf = 16'hACE1;

  logic obs_da, obs_db, obs_la, obs_lb;
  logic [LEN_W-1:0] obs_lena, obs_lenb;

  always #(CLK_P/2) cclk = ~cclk;

  dchain_slave #(.OWN_BITS(OWN_A)) dut (
    .cclk(cclk), .rst(rst), .din(din), .dout(dout_a),
    .length_count(len_a), .loaded(loaded_a));

  dchain_slave #(.OWN_BITS(OWN_B)) dut_min (
    .cclk(cclk), .rst(rst), .din(din), .dout(dout_b),
    .length_count(len_b), .loaded(loaded_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one bit just after a falling edge; sample outputs at the same point.
  task automatic push(input logic b);
    @(negedge cclk);
    #1;
    obs_da = dout_a;  obs_db = dout_b;
    obs_la = loaded_a; obs_lb = loaded_b;
    obs_lena = len_a; obs_lenb = len_b;
    din = b;
  endtask

  task automatic do_reset(input int cycles);
    @(negedge cclk);
    #1 rst = 1'b1;
    din = 1'b1;
    repeat (cycles) @(posedge cclk);
    @(negedge cclk);
    #1 rst = 1'b0;
  endtask

  task automatic idle_checks(input string req);
    chk({req, " dout"},   32'(obs_da),   32'd1);
    chk({req, " loaded"}, 32'(obs_la),   32'd0);
    chk({req, " length"}, 32'(obs_lena), 32'd0);
    chk({req, " dout min"},   32'(obs_db), 32'd1);
    chk({req, " loaded min"}, 32'(obs_lb), 32'd0);
  endtask

  function automatic logic lfsr_bit();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[0];
  endfunction

  task automatic add_bits(input logic [31:0] v, input int w);
    for (int k = w - 1; k >= 0; k--) begin
      stream[slen] = v[k];
      slen++;
    end
  endtask

  task automatic t_reset_state();
    for (int k = 0; k < 3; k++) begin
      push(1'b1);
      idle_checks("R8 after reset");
    end
  endtask

  task automatic t_no_sync();
    for (int k = 0; k < 16; k++) begin
      push(k[0]);
      idle_checks("R1 alternating");
    end
    for (int k = 0; k < 10; k++) begin
      push(1'b0);
      idle_checks("R1 zeros");
    end
    for (int k = 7; k >= 0; k--) begin
      push(8'hB4 >> k);
      idle_checks("R1 near miss");
    end
  endtask

  task automatic t_chain(input int junk, input logic [LEN_W-1:0] lenv, input int nsur);
    int hend;
    slen = 0;
    for (int k = 0; k < junk; k++) add_bits(32'd1, 1);
    add_bits(32'hB5, 8);
    add_bits(32'(lenv), LEN_W);
    hend = slen - 1;
    add_bits(32'hB5, 8);
    for (int k = 0; k < OWN_A - 8; k++) add_bits(32'(lfsr_bit()), 1);
    for (int k = 0; k < nsur; k++) add_bits(32'(lfsr_bit()), 1);
    add_bits(32'hB5, 8);
    add_bits(32'd1, 1);
    for (int i = 0; i < slen; i++) begin
      push(stream[i]);
      if (i >= 1) begin
        int  j;
        logic ed, edb;
        j   = i - 1;
        ed  = (j >= hend + OWN_A + 1) ? stream[j] : 1'b1;
        edb = (j >= hend + OWN_B + 1) ? stream[j] : 1'b1;
        if (j >= hend + OWN_A + 1) chk("R5 forwarded bit", 32'(obs_da), 32'(ed));
        else if (j > hend)         chk("R3 own bit withheld", 32'(obs_da), 32'(ed));
        else                       chk("R6 header dout idle", 32'(obs_da), 32'(ed));
        chk("R4 loaded", 32'(obs_la), 32'(j >= hend + OWN_A));
        if (j > hend) chk("R7 length held", 32'(obs_lena), 32'(lenv));
        else if (j == hend) chk("R2 length shown", 32'(obs_lena), 32'(lenv));
        else chk("R2 length zero before end", 32'(obs_lena), 32'd0);
        chk("R9 min dout", 32'(obs_db), 32'(edb));
        chk("R9 min loaded", 32'(obs_lb), 32'(j >= hend + OWN_B));
        chk("R9 min length", 32'(obs_lenb), (j >= hend) ? 32'(lenv) : 32'd0);
      end
    end
  endtask

  task automatic t_reset_mid();
    push(1'b0);
    chk("R4 loaded before reset", 32'(obs_la), 32'd1);
    do_reset(2);
    push(1'b1);
    idle_checks("R8 reset in pass-through");
    for (int k = 0; k < 4; k++) begin
      push(1'b0);
      idle_checks("R8 back to search");
    end
  endtask

  initial begin
    do_reset(3);
    t_reset_state();
    t_no_sync();
    t_chain(0, 24'hA53C0F, 30);
    t_reset_mid();
    do_reset(2);
    t_chain(5, 24'h800001, 24);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule